// File: doc/BRIEF.md
# Frame-Based Black Level Servo

This block holds the sensor black level on target with a slow closed loop that acts once per frame. While a frame streams in, it sums a fixed number of pixels from the optically dark rows and forms their mean. At the start of the next frame, it passes that mean through an exponential low-pass filter that spans many frames. It then compares the filtered level with a programmable window and nudges a signed 8-bit offset code up or down by a programmable step. The code saturates and never wraps.

The applied code can be forced to a programmed manual value for use with an external calibration loop. The automatic servo keeps running underneath and stays visible on a readback output. The pixel input is a valid/ready stream, but the block never applies back-pressure: `s_ready` is tied high and every valid cycle is a beat. Configuration and the two code outputs are plain levels. The configuration is sampled on the start-of-frame beat.

Top module: `black_level_servo`

## Requirements
- R1: After reset, `offset_code` and `rd_auto` are 0 and the filter holds no measurement.
- R2: `s_ready` is always 1. A beat is any cycle with `s_valid` high. `s_sof`=1 marks the first beat of a frame, and `s_dark`=1 marks a beat carrying a dark-row pixel.
- R3: A frame's measurement covers the first 2·2^ROW_LG2 dark beats of that frame, counting from its start-of-frame beat. It covers only the first 2^ROW_LG2 dark beats when `cfg_bin4`=1 on that start-of-frame beat. The mean is the sum shifted right by log2 of that count. Dark beats beyond the count are ignored.
- R4: A frame that delivers fewer dark beats than R3 requires produces no measurement. At the next start of frame, the filter and `rd_auto` stay unchanged.
- R5: The first complete measurement after reset loads the filter directly. Each later one updates it as filt + ((mean − filt) >>> `cfg_filt_k`), using a signed difference and an arithmetic shift.
- R6: After a filter update, a filtered level below `cfg_thr_lo` raises the automatic code by `cfg_step`. A level above `cfg_thr_hi` lowers it by `cfg_step`. A level inside the window, bounds included, leaves it unchanged.
- R7: The automatic code saturates at +127 and −128.
- R8: Both codes change only in the cycle after a start-of-frame beat, and that beat acts on the previous frame's measurement. They are stable at all other times.
- R9: When `cfg_manual`=1 on a start-of-frame beat, `offset_code` takes `cfg_manual_val` in the next cycle, while `rd_auto` keeps servoing.
- R10: When `cfg_manual`=0 on a start-of-frame beat, `offset_code` equals `rd_auto` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Pixel beat valid |
| s_ready | output | 1 | Always 1, no back-pressure |
| s_data | input | PIX_W | Pixel value, unsigned |
| s_sof | input | 1 | First beat of a frame |
| s_dark | input | 1 | Beat is a dark-row pixel |
| cfg_bin4 | input | 1 | Measure one dark row instead of two |
| cfg_thr_lo | input | PIX_W | Lower window bound |
| cfg_thr_hi | input | PIX_W | Upper window bound |
| cfg_step | input | STEP_W | Code step size (2 suggested) |
| cfg_filt_k | input | K_W | Filter shift amount |
| cfg_manual | input | 1 | Apply the manual code |
| cfg_manual_val | input | CODE_W | Manual signed code |
| offset_code | output | CODE_W | Applied signed offset code |
| rd_auto | output | CODE_W | Automatic servo code, readback |

## Verification
Dark rows at a uniform low level drive the servo upward, and dark rows at a high level drive it downward. Levels inside the window show that the window bounds hold the code. A long run against an impossible window reaches both saturation limits, which separates clamping from wrap-around. A slow filter setting with an abrupt level change tells a correct shift-based average from direct use of the sample. Short frames, surplus bright dark pixels and the one-row mode check that only the right pixels count. Toggling the manual bit separates the applied code from the readback.

// File: rtl/blk_servo_pkg.sv
package blk_servo_pkg;
  typedef enum logic [1:0] {
    DEC_HOLD = 2'd0,
    DEC_UP   = 2'd1,
    DEC_DOWN = 2'd2
  } step_dec_e;
endpackage

// File: rtl/blk_dark_meter.sv
module blk_dark_meter #(
  parameter int PIX_W   = 10,
  parameter int ROW_LG2 = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             sof,
  input  logic             dark,
  input  logic [PIX_W-1:0] data,
  input  logic             bin4,
  output logic             meas_ok,
  output logic [PIX_W-1:0] meas_avg
);
  localparam int SUM_W = PIX_W + ROW_LG2 + 1;
  localparam int CNT_W = ROW_LG2 + 2;
  localparam logic [CNT_W-1:0] TGT_ONE = CNT_W'(1 << ROW_LG2);
  localparam logic [CNT_W-1:0] TGT_TWO = CNT_W'(2 << ROW_LG2);

  logic [SUM_W-1:0] sum_q;
  logic [CNT_W-1:0] cnt_q;
  logic             bin4_q;
  logic [CNT_W-1:0] target;
  logic             full;
  logic             take;
  logic [SUM_W-1:0] avg_wide;

  assign target = bin4_q ? TGT_ONE : TGT_TWO;
  assign full   = (cnt_q == target);
  // at start of frame the counters restart, so the old fill state is irrelevant
  assign take   = beat && dark && (sof || !full);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_q  <= '0;
      cnt_q  <= '0;
      bin4_q <= 1'b0;
    end else if (beat && sof) begin
      bin4_q <= bin4;
      sum_q  <= take ? SUM_W'(data) : '0;
      cnt_q  <= take ? CNT_W'(1) : '0;
    end else if (take) begin
      sum_q <= sum_q + SUM_W'(data);
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign avg_wide = bin4_q ? (sum_q >> ROW_LG2) : (sum_q >> (ROW_LG2 + 1));
  assign meas_avg = avg_wide[PIX_W-1:0];
  assign meas_ok  = full;
endmodule

// File: rtl/blk_ema.sv
module blk_ema #(
  parameter int PIX_W = 10,
  parameter int K_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic [PIX_W-1:0] sample,
  input  logic [K_W-1:0]   k,
  output logic [PIX_W-1:0] filt_next
);
  logic [PIX_W-1:0]        filt_q;
  logic                    seeded_q;
  logic signed [PIX_W:0]   diff;
  logic signed [PIX_W:0]   delta;
  logic signed [PIX_W:0]   nsum;

  always_comb begin
    diff  = $signed({1'b0, sample}) - $signed({1'b0, filt_q});
    delta = diff >>> k;
    nsum  = $signed({1'b0, filt_q}) + delta;
    filt_next = seeded_q ? nsum[PIX_W-1:0] : sample;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filt_q   <= '0;
      seeded_q <= 1'b0;
    end else if (upd) begin
      filt_q   <= filt_next;
      seeded_q <= 1'b1;
    end
  end
endmodule

// File: rtl/blk_offset_servo.sv
module blk_offset_servo
  import blk_servo_pkg::*;
#(
  parameter int PIX_W  = 10,
  parameter int CODE_W = 8,
  parameter int STEP_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     upd,
  input  logic [PIX_W-1:0]         level,
  input  logic [PIX_W-1:0]         thr_lo,
  input  logic [PIX_W-1:0]         thr_hi,
  input  logic [STEP_W-1:0]        step,
  output logic signed [CODE_W-1:0] code_q,
  output logic signed [CODE_W-1:0] code_next
);
  localparam int XW = CODE_W + 2;
  localparam logic signed [XW-1:0] LIM_HI = XW'((1 <<< (CODE_W - 1)) - 1);
  localparam logic signed [XW-1:0] LIM_LO = XW'(-(1 <<< (CODE_W - 1)));

  step_dec_e              dec;
  logic signed [XW-1:0]   code_x;
  logic signed [XW-1:0]   step_x;
  logic signed [XW-1:0]   trial;

  always_comb begin
    if (level < thr_lo)      dec = DEC_UP;
    else if (level > thr_hi) dec = DEC_DOWN;
    else                     dec = DEC_HOLD;
  end

  always_comb begin
    code_x = {{2{code_q[CODE_W-1]}}, code_q};
    step_x = $signed({{(XW - STEP_W){1'b0}}, step});
    case (dec)
      DEC_UP:   trial = code_x + step_x;
      DEC_DOWN: trial = code_x - step_x;
      default:  trial = code_x;
    endcase
    if (!upd)                code_next = code_q;
    else if (trial > LIM_HI) code_next = LIM_HI[CODE_W-1:0];
    else if (trial < LIM_LO) code_next = LIM_LO[CODE_W-1:0];
    else                     code_next = trial[CODE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_next;
  end
endmodule

// File: rtl/black_level_servo.sv
module black_level_servo #(
  parameter int PIX_W   = 10,
  parameter int ROW_LG2 = 4,
  parameter int CODE_W  = 8,
  parameter int STEP_W  = 4,
  parameter int K_W     = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     s_valid,
  output logic                     s_ready,
  input  logic [PIX_W-1:0]         s_data,
  input  logic                     s_sof,
  input  logic                     s_dark,
  input  logic                     cfg_bin4,
  input  logic [PIX_W-1:0]         cfg_thr_lo,
  input  logic [PIX_W-1:0]         cfg_thr_hi,
  input  logic [STEP_W-1:0]        cfg_step,
  input  logic [K_W-1:0]           cfg_filt_k,
  input  logic                     cfg_manual,
  input  logic signed [CODE_W-1:0] cfg_manual_val,
  output logic signed [CODE_W-1:0] offset_code,
  output logic signed [CODE_W-1:0] rd_auto
);
  logic                     beat;
  logic                     sof_beat;
  logic                     meas_ok;
  logic [PIX_W-1:0]         meas_avg;
  logic                     upd;
  logic [PIX_W-1:0]         filt_next;
  logic signed [CODE_W-1:0] auto_next;

  assign s_ready  = 1'b1;
  assign beat     = s_valid && s_ready;
  assign sof_beat = beat && s_sof;
  assign upd      = sof_beat && meas_ok;

  blk_dark_meter #(.PIX_W(PIX_W), .ROW_LG2(ROW_LG2)) i_meter (
    .clk(clk), .rst_n(rst_n), .beat(beat), .sof(s_sof), .dark(s_dark),
    .data(s_data), .bin4(cfg_bin4), .meas_ok(meas_ok), .meas_avg(meas_avg)
  );

  blk_ema #(.PIX_W(PIX_W), .K_W(K_W)) i_ema (
    .clk(clk), .rst_n(rst_n), .upd(upd), .sample(meas_avg),
    .k(cfg_filt_k), .filt_next(filt_next)
  );

  blk_offset_servo #(.PIX_W(PIX_W), .CODE_W(CODE_W), .STEP_W(STEP_W)) i_servo (
    .clk(clk), .rst_n(rst_n), .upd(upd), .level(filt_next),
    .thr_lo(cfg_thr_lo), .thr_hi(cfg_thr_hi), .step(cfg_step),
    .code_q(rd_auto), .code_next(auto_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        offset_code <= '0;
    else if (sof_beat) offset_code <= cfg_manual ? cfg_manual_val : auto_next;
  end
endmodule

// File: rtl/blk_servo_chk.sv
module blk_servo_chk #(
  parameter int PIX_W  = 10,
  parameter int CODE_W = 8,
  parameter int STEP_W = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     s_valid,
  input logic                     s_ready,
  input logic                     s_sof,
  input logic [STEP_W-1:0]        cfg_step,
  input logic                     cfg_manual,
  input logic signed [CODE_W-1:0] cfg_manual_val,
  input logic signed [CODE_W-1:0] offset_code,
  input logic signed [CODE_W-1:0] rd_auto
);
  logic sof_beat;
  assign sof_beat = s_valid && s_ready && s_sof;

  p_always_ready_r2: assert property (@(posedge clk) disable iff (!rst_n) s_ready);

  p_stable_between_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sof_beat) |-> ($stable(offset_code) && $stable(rd_auto)));

  p_manual_applied_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sof_beat && cfg_manual) |-> (offset_code == $past(cfg_manual_val)));

  p_readback_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sof_beat && !cfg_manual) |-> (offset_code == rd_auto));

  p_step_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sof_beat |=> (((int'(rd_auto) - int'($past(rd_auto))) <= int'($past(cfg_step))) &&
                  ((int'($past(rd_auto)) - int'(rd_auto)) <= int'($past(cfg_step)))));
endmodule

bind black_level_servo blk_servo_chk #(.PIX_W(PIX_W), .CODE_W(CODE_W), .STEP_W(STEP_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_sof(s_sof),
  .cfg_step(cfg_step), .cfg_manual(cfg_manual), .cfg_manual_val(cfg_manual_val),
  .offset_code(offset_code), .rd_auto(rd_auto)
);

// File: tb/test_black_level_servo.sv
module test_black_level_servo;
  localparam int CLK_P  = 10;
  localparam int PIX_W  = 10;
  localparam int ROW_LG2 = 4;
  localparam int ROW_N  = 1 << ROW_LG2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0;
  logic s_ready;
  logic [PIX_W-1:0] s_data = '0;
  logic s_sof = 1'b0, s_dark = 1'b0;
  logic cfg_bin4 = 1'b0;
  logic [PIX_W-1:0] cfg_thr_lo = 10'd40, cfg_thr_hi = 10'd60;
  logic [3:0] cfg_step = 4'd2;
  logic [2:0] cfg_filt_k = 3'd0;
  logic cfg_manual = 1'b0;
  logic signed [7:0] cfg_manual_val = '0;
  logic signed [7:0] offset_code, rd_auto;

  int n_chk = 0, n_fail = 0;
  int m_filt = 0, m_code = 0, m_pend_avg = 0;
  bit m_seeded = 0, m_pend = 0;

  always #(CLK_P/2) clk = ~clk;

  black_level_servo i_black_level_servo (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_sof(s_sof), .s_dark(s_dark), .cfg_bin4(cfg_bin4), .cfg_thr_lo(cfg_thr_lo),
    .cfg_thr_hi(cfg_thr_hi), .cfg_step(cfg_step), .cfg_filt_k(cfg_filt_k),
    .cfg_manual(cfg_manual), .cfg_manual_val(cfg_manual_val),
    .offset_code(offset_code), .rd_auto(rd_auto)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic push(input bit sof, input bit dark, input int data);
    @(negedge clk);
    s_valid = 1'b1; s_sof = sof; s_dark = dark; s_data = PIX_W'(data);
    @(posedge clk); #1;
    s_valid = 1'b0; s_sof = 1'b0; s_dark = 1'b0;
  endtask

  // model of the start-of-frame update
  task automatic model_sof();
    if (m_pend) begin
      if (!m_seeded) begin m_filt = m_pend_avg; m_seeded = 1; end
      else m_filt = m_filt + ((m_pend_avg - m_filt) >>> cfg_filt_k);
      if (m_filt < int'(cfg_thr_lo)) m_code = m_code + int'(cfg_step);
      else if (m_filt > int'(cfg_thr_hi)) m_code = m_code - int'(cfg_step);
      if (m_code > 127) m_code = 127;
      if (m_code < -128) m_code = -128;
    end
  endtask

  // one frame: sof beat, nd dark beats (base + i%5), then active beats
  task automatic do_frame(input int nd, input int base, input bit bin4, input string req);
    int need, sum, exp_off;
    cfg_bin4 = bin4;
    push(1'b1, 1'b0, 1023);
    model_sof();
    exp_off = cfg_manual ? int'(cfg_manual_val) : m_code;
    @(negedge clk);
    chk(req, int'(rd_auto), m_code);
    chk(req, int'(offset_code), exp_off);
    need = bin4 ? ROW_N : 2 * ROW_N;
    sum = 0;
    for (int i = 0; i < nd; i++) begin
      int v;
      v = (i < need) ? base + (i % 5) : 1023;
      if (i < need) sum += v;
      push(1'b0, 1'b1, v);
      if (i == 3) @(negedge clk);
    end
    push(1'b0, 1'b0, 1000);
    push(1'b0, 1'b0, 0);
    m_pend = (nd >= need);
    m_pend_avg = bin4 ? (sum >>> ROW_LG2) : (sum >>> (ROW_LG2 + 1));
    @(negedge clk);
    chk("R8", int'(offset_code), exp_off);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", int'(offset_code), 0);
    chk("R1", int'(rd_auto), 0);
    chk("R2", int'(s_ready), 1);
  endtask

  task automatic t_window_hold();
    cfg_thr_lo = 40; cfg_thr_hi = 60; cfg_step = 2; cfg_filt_k = 0;
    for (int f = 0; f < 3; f++) do_frame(2 * ROW_N, 48, 1'b0, "R6");
    do_frame(2 * ROW_N, 58, 1'b0, "R6");
    do_frame(2 * ROW_N, 58, 1'b0, "R6");
  endtask

  task automatic t_step_up();
    for (int f = 0; f < 4; f++) do_frame(2 * ROW_N, 10, 1'b0, "R6");
  endtask

  task automatic t_filter();
    cfg_filt_k = 2;
    for (int f = 0; f < 5; f++) do_frame(2 * ROW_N, 300, 1'b0, "R5");
    cfg_filt_k = 0;
  endtask

  task automatic t_incomplete();
    do_frame(2 * ROW_N - 1, 0, 1'b0, "R4");
    do_frame(2 * ROW_N, 48, 1'b0, "R4");
    do_frame(ROW_N, 0, 1'b0, "R4");
    do_frame(2 * ROW_N, 48, 1'b0, "R4");
  endtask

  task automatic t_bin4_extra();
    do_frame(ROW_N, 5, 1'b1, "R3");
    do_frame(2 * ROW_N + 6, 5, 1'b0, "R3");
    do_frame(ROW_N + 9, 2, 1'b1, "R3");
    do_frame(2 * ROW_N, 48, 1'b0, "R3");
  endtask

  task automatic t_saturate();
    cfg_thr_lo = 1023; cfg_thr_hi = 1023; cfg_step = 15;
    for (int f = 0; f < 12; f++) do_frame(2 * ROW_N, 0, 1'b0, "R7");
    chk("R7", int'(rd_auto), 127);
    cfg_thr_lo = 0; cfg_thr_hi = 0;
    for (int f = 0; f < 20; f++) do_frame(2 * ROW_N, 500, 1'b0, "R7");
    chk("R7", int'(rd_auto), -128);
  endtask

  task automatic t_manual();
    cfg_thr_lo = 1023; cfg_thr_hi = 1023; cfg_step = 3;
    cfg_manual = 1; cfg_manual_val = -37;
    for (int f = 0; f < 3; f++) do_frame(2 * ROW_N, 0, 1'b0, "R9");
    cfg_manual_val = 55;
    do_frame(2 * ROW_N, 0, 1'b0, "R9");
    cfg_manual = 0;
    do_frame(2 * ROW_N, 0, 1'b0, "R10");
    do_frame(2 * ROW_N, 0, 1'b0, "R10");
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_window_hold();
    t_step_up();
    t_filter();
    t_incomplete();
    t_bin4_extra();
    t_saturate();
    t_manual();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule